// File: doc/BRIEF.md
# System Console Register Window

This block is a slave register window on a simple single-beat memory bus. Boot firmware uses it to find out about the machine it runs on, to start disk reads, to print and read characters, and to release secondary CPUs. The window is 128 bytes, and only the low seven address bits select a location. Fixed system facts live in the window: a layout marker, a revision number, the CPU count, the timer interrupt rate, the CPU clock, the memory size and the kernel image bounds and entry. All of them come from module parameters.

Some writes cause effects outside the block, and these leave the block as one-cycle strobes. A disk-read request carries the stored transfer address, block and count. A character strobe carries one byte. A CPU-launch strobe carries a CPU number and the stored start-context pointer. Reads at the input-character location pull a live byte from an upstream character source over a valid/ready pair. Every request gets a response exactly one cycle later. The response carries read data and an error flag. The flag is raised for an illegal size, a misaligned address, a write the map does not allow, or a write value that the map rejects.

Top module: `sys_console_regs`

## Requirements
- R1: Every cycle with `req_valid` high produces `rsp_valid` high in the next cycle. A cycle without a request produces no response in the next cycle.
- R2: A request whose size is not 4 or 8 bytes, or whose offset is not a multiple of its size, gets `rsp_fault`. It changes no register and raises no strobe.
- R3: A 4-byte read returns the 32-bit word at that offset, zero-extended. An 8-byte read returns the word at the offset in bits 31:0 and the next word in bits 63:32. The fixed words are: 0x00 layout marker, 0x04 revision, 0x08 CPU count and 0x0C interrupt rate, each 32 bits. The 64-bit values are: 0x10 CPU MHz, 0x18 memory size, 0x20 kernel start, 0x28 kernel end and 0x30 entry.
- R4: An 8-byte or 4-byte read at 0x68 while `in_valid` is high returns `in_data` zero-extended. It raises `in_ready` for exactly that request cycle. With `in_valid` low, the read returns 0 and does not raise `in_ready`. A read at 0x6C returns 0 and never pops.
- R5: Writes at 0x38 (disk unit), 0x40 (transfer count), 0x48 (transfer address), 0x50 (block) and 0x70 (start context) store the value and read back from there. A 4-byte write stores its low 32 bits with the upper half cleared.
- R6: Writing exactly 0x13 at 0x58 raises `disk_valid` in the response cycle, with the stored address, block and count. Any other value at 0x58 gets `rsp_fault` and no strobe.
- R7: A write at 0x60 raises `char_valid` in the response cycle, with bits 7:0 of the write data on `char_data`.
- R8: A write at 0x78 whose low 32 bits are nonzero raises `cpu_start_valid` in the response cycle. It carries that value as `cpu_start_id` and the stored start context as `cpu_start_param`. A zero value gets `rsp_fault` and no strobe.
- R9: A write at any other offset gets `rsp_fault` and changes no stored value. This covers the fixed words, the upper halves of 64-bit fields, 0x68 and 0x7C.
- R10: After reset, `rsp_valid` and all strobes are low and every writable register reads 0.
- R11: Address bits above bit 6 are ignored, so any alias of an offset behaves like the offset itself.
- R12: At most one strobe is high in any cycle. A strobe is only ever high together with a response that has no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; only bits 6:0 decode |
| req_size | input | 4 | Access size in bytes (4 or 8 legal) |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_rdata | output | 64 | Read data |
| rsp_fault | output | 1 | Access error for the responded request |
| in_valid | input | 1 | Input character available |
| in_data | input | 8 | Input character |
| in_ready | output | 1 | Pops the input character |
| char_valid | output | 1 | Output character strobe |
| char_data | output | 8 | Output character |
| disk_valid | output | 1 | Disk-read request strobe |
| disk_paddr | output | 64 | Transfer address |
| disk_block | output | 64 | Starting block |
| disk_count | output | 64 | Transfer count |
| cpu_start_valid | output | 1 | CPU launch strobe |
| cpu_start_id | output | CPU_ID_W | CPU to launch |
| cpu_start_param | output | 64 | Start context pointer |

## Verification
The assertions take two things for granted. The first is that `req_wdata` and `req_size` are known whenever `req_valid` is high. The second is that `in_valid` holds steady through a request cycle, since `in_ready` is a combinational reply to it. The bench drives the request and the input source only on falling edges. It samples `in_ready` in the middle of the request cycle and samples every registered output after the following rising edge. It leaves an idle cycle between requests so that the check for a missing response in R1 is observed as well.

// File: rtl/scon_pkg.sv
package scon_pkg;
  localparam int WIN_W    = 7;
  localparam int NUM_WORD = 32;
  localparam int NUM_WREG = 5;

  localparam int IDX_UNIT   = 0;
  localparam int IDX_COUNT  = 1;
  localparam int IDX_PADDR  = 2;
  localparam int IDX_BLOCK  = 3;
  localparam int IDX_IMPURE = 4;

  localparam logic [WIN_W-1:0] OFF_UNIT   = 7'h38;
  localparam logic [WIN_W-1:0] OFF_COUNT  = 7'h40;
  localparam logic [WIN_W-1:0] OFF_PADDR  = 7'h48;
  localparam logic [WIN_W-1:0] OFF_BLOCK  = 7'h50;
  localparam logic [WIN_W-1:0] OFF_DISKOP = 7'h58;
  localparam logic [WIN_W-1:0] OFF_OUTC   = 7'h60;
  localparam logic [WIN_W-1:0] OFF_INC    = 7'h68;
  localparam logic [WIN_W-1:0] OFF_IMPURE = 7'h70;
  localparam logic [WIN_W-1:0] OFF_BCPU   = 7'h78;

  localparam logic [63:0] DISK_READ_CODE = 64'h13;

  typedef struct packed {
    logic disk;
    logic chr;
    logic cpu;
  } fire_t;
endpackage

// File: rtl/scon_decode.sv
module scon_decode
  import scon_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CPU_ID_W = 32
) (
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [3:0]          req_size,
  input  logic [63:0]         req_wdata,
  output logic                fault,
  output logic                rd_en,
  output logic                rd_input,
  output logic                rd_wide,
  output logic [4:0]          rd_word,
  output logic [NUM_WREG-1:0] wr_en,
  output logic [63:0]         wval,
  output fire_t               fire
);
  logic [WIN_W-1:0] off;
  logic             size_ok;
  logic             align_ok;
  logic             unused_addr_hi;

  assign off            = req_addr[WIN_W-1:0];
  assign unused_addr_hi = ^req_addr[ADDR_W-1:WIN_W];
  assign rd_word        = off[WIN_W-1:2];
  assign rd_wide        = (req_size == 4'd8);

  always_comb begin
    size_ok  = (req_size == 4'd4) || (req_size == 4'd8);
    align_ok = (req_size == 4'd8) ? (off[2:0] == 3'b000) : (off[1:0] == 2'b00);
    wval     = (req_size == 4'd4) ? {32'b0, req_wdata[31:0]} : req_wdata;
    fault    = 1'b0;
    rd_en    = 1'b0;
    rd_input = 1'b0;
    wr_en    = '0;
    fire     = '0;
    if (req_valid) begin
      if (!(size_ok && align_ok)) begin
        fault = 1'b1;
      end else if (!req_write) begin
        rd_en    = 1'b1;
        rd_input = (off == OFF_INC);
      end else begin
        case (off)
          OFF_UNIT:   wr_en[IDX_UNIT]   = 1'b1;
          OFF_COUNT:  wr_en[IDX_COUNT]  = 1'b1;
          OFF_PADDR:  wr_en[IDX_PADDR]  = 1'b1;
          OFF_BLOCK:  wr_en[IDX_BLOCK]  = 1'b1;
          OFF_IMPURE: wr_en[IDX_IMPURE] = 1'b1;
          OFF_DISKOP: begin
            if (wval == DISK_READ_CODE) fire.disk = 1'b1;
            else                        fault     = 1'b1;
          end
          OFF_OUTC:   fire.chr = 1'b1;
          OFF_BCPU: begin
            if (wval[CPU_ID_W-1:0] != '0) fire.cpu = 1'b1;
            else                          fault    = 1'b1;
          end
          default:    fault = 1'b1;
        endcase
      end
    end
  end

  // R9: a fault never comes with a register write.
  always_comb begin
    assert_fault_no_write_R9: assert (!(fault && (wr_en != '0)));
  end
endmodule

// File: rtl/scon_wregs.sv
module scon_wregs
  import scon_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_WREG-1:0]       wr_en,
  input  logic [63:0]               wval,
  output logic [NUM_WREG-1:0][63:0] regs_q
);
  for (genvar g = 0; g < NUM_WREG; g++) begin : g_reg
    logic [63:0] d;
    always_comb d = wr_en[g] ? wval : regs_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        regs_q[g] <= '0;
      else if (wr_en[g]) regs_q[g] <= d;
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[g] |=> $stable(regs_q[g]));
  end
endmodule

// File: rtl/scon_rdmux.sv
module scon_rdmux
  import scon_pkg::*;
#(
  parameter logic [31:0] P_LAYOUT   = 32'h0000_007C,
  parameter logic [31:0] P_REVISION = 32'h0000_0A01,
  parameter logic [31:0] P_NCPU     = 32'd4,
  parameter logic [31:0] P_TICK_HZ  = 32'd1024,
  parameter logic [63:0] P_CPU_MHZ  = 64'd500,
  parameter logic [63:0] P_MEM_SIZE = 64'h0000_0000_4000_0000,
  parameter logic [63:0] P_KSTART   = 64'hFFFF_FC00_0031_0000,
  parameter logic [63:0] P_KEND     = 64'hFFFF_FC00_0040_0000,
  parameter logic [63:0] P_ENTRY    = 64'hFFFF_FC00_0031_0100
) (
  input  logic [4:0]                rd_word,
  input  logic                      rd_wide,
  input  logic                      rd_input,
  input  logic [NUM_WREG-1:0][63:0] regs_q,
  input  logic                      in_valid,
  input  logic [7:0]                in_data,
  output logic [63:0]               rdata,
  output logic                      pop
);
  logic [31:0] words [NUM_WORD];
  logic [31:0] lo;
  logic [31:0] hi;
  logic [4:0]  hi_idx;

  always_comb begin
    for (int i = 0; i < NUM_WORD; i++) words[i] = '0;
    words[0]  = P_LAYOUT;
    words[1]  = P_REVISION;
    words[2]  = P_NCPU;
    words[3]  = P_TICK_HZ;
    words[4]  = P_CPU_MHZ[31:0];
    words[5]  = P_CPU_MHZ[63:32];
    words[6]  = P_MEM_SIZE[31:0];
    words[7]  = P_MEM_SIZE[63:32];
    words[8]  = P_KSTART[31:0];
    words[9]  = P_KSTART[63:32];
    words[10] = P_KEND[31:0];
    words[11] = P_KEND[63:32];
    words[12] = P_ENTRY[31:0];
    words[13] = P_ENTRY[63:32];
    words[14] = regs_q[IDX_UNIT][31:0];
    words[15] = regs_q[IDX_UNIT][63:32];
    words[16] = regs_q[IDX_COUNT][31:0];
    words[17] = regs_q[IDX_COUNT][63:32];
    words[18] = regs_q[IDX_PADDR][31:0];
    words[19] = regs_q[IDX_PADDR][63:32];
    words[20] = regs_q[IDX_BLOCK][31:0];
    words[21] = regs_q[IDX_BLOCK][63:32];
    words[26] = in_valid ? {24'b0, in_data} : 32'b0;
    words[28] = regs_q[IDX_IMPURE][31:0];
    words[29] = regs_q[IDX_IMPURE][63:32];
  end

  assign hi_idx = rd_word + 5'd1;
  assign lo     = words[rd_word];
  assign hi     = words[hi_idx];
  assign rdata  = rd_wide ? {hi, lo} : {32'b0, lo};
  assign pop    = rd_input && in_valid;
endmodule

// File: rtl/sys_console_regs.sv
module sys_console_regs
  import scon_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          CPU_ID_W   = 32,
  parameter logic [31:0] P_LAYOUT   = 32'h0000_007C,
  parameter logic [31:0] P_REVISION = 32'h0000_0A01,
  parameter logic [31:0] P_NCPU     = 32'd4,
  parameter logic [31:0] P_TICK_HZ  = 32'd1024,
  parameter logic [63:0] P_CPU_MHZ  = 64'd500,
  parameter logic [63:0] P_MEM_SIZE = 64'h0000_0000_4000_0000,
  parameter logic [63:0] P_KSTART   = 64'hFFFF_FC00_0031_0000,
  parameter logic [63:0] P_KEND     = 64'hFFFF_FC00_0040_0000,
  parameter logic [63:0] P_ENTRY    = 64'hFFFF_FC00_0031_0100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [3:0]          req_size,
  input  logic [63:0]         req_wdata,
  output logic                rsp_valid,
  output logic [63:0]         rsp_rdata,
  output logic                rsp_fault,
  input  logic                in_valid,
  input  logic [7:0]          in_data,
  output logic                in_ready,
  output logic                char_valid,
  output logic [7:0]          char_data,
  output logic                disk_valid,
  output logic [63:0]         disk_paddr,
  output logic [63:0]         disk_block,
  output logic [63:0]         disk_count,
  output logic                cpu_start_valid,
  output logic [CPU_ID_W-1:0] cpu_start_id,
  output logic [63:0]         cpu_start_param
);
  logic                      fault;
  logic                      rd_en;
  logic                      rd_input;
  logic                      rd_wide;
  logic [4:0]                rd_word;
  logic [NUM_WREG-1:0]       wr_en;
  logic [63:0]               wval;
  fire_t                     fire;
  logic [NUM_WREG-1:0][63:0] regs_q;
  logic [63:0]               rdata;

  scon_decode #(.ADDR_W(ADDR_W), .CPU_ID_W(CPU_ID_W)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .fault     (fault),
    .rd_en     (rd_en),
    .rd_input  (rd_input),
    .rd_wide   (rd_wide),
    .rd_word   (rd_word),
    .wr_en     (wr_en),
    .wval      (wval),
    .fire      (fire)
  );

  scon_wregs u_wregs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wval   (wval),
    .regs_q (regs_q)
  );

  scon_rdmux #(
    .P_LAYOUT  (P_LAYOUT),  .P_REVISION (P_REVISION), .P_NCPU  (P_NCPU),
    .P_TICK_HZ (P_TICK_HZ), .P_CPU_MHZ  (P_CPU_MHZ),  .P_MEM_SIZE (P_MEM_SIZE),
    .P_KSTART  (P_KSTART),  .P_KEND     (P_KEND),     .P_ENTRY (P_ENTRY)
  ) u_rdmux (
    .rd_word  (rd_word),
    .rd_wide  (rd_wide),
    .rd_input (rd_input),
    .regs_q   (regs_q),
    .in_valid (in_valid),
    .in_data  (in_data),
    .rdata    (rdata),
    .pop      (in_ready)
  );

  // next-state
  logic [63:0]         rdata_d;
  logic [7:0]          char_d;
  logic [CPU_ID_W-1:0] cpu_id_d;

  always_comb begin
    rdata_d  = rd_en ? rdata : 64'b0;
    char_d   = wval[7:0];
    cpu_id_d = wval[CPU_ID_W-1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid       <= 1'b0;
      rsp_fault       <= 1'b0;
      char_valid      <= 1'b0;
      disk_valid      <= 1'b0;
      cpu_start_valid <= 1'b0;
    end else begin
      rsp_valid       <= req_valid;
      rsp_fault       <= fault;
      char_valid      <= fire.chr;
      disk_valid      <= fire.disk;
      cpu_start_valid <= fire.cpu;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rsp_rdata <= '0;
    else if (req_valid) rsp_rdata <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        char_data <= '0;
    else if (fire.chr) char_data <= char_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disk_paddr <= '0;
      disk_block <= '0;
      disk_count <= '0;
    end else if (fire.disk) begin
      disk_paddr <= regs_q[IDX_PADDR];
      disk_block <= regs_q[IDX_BLOCK];
      disk_count <= regs_q[IDX_COUNT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_start_id    <= '0;
      cpu_start_param <= '0;
    end else if (fire.cpu) begin
      cpu_start_id    <= cpu_id_d;
      cpu_start_param <= regs_q[IDX_IMPURE];
    end
  end

  // assertions
  assert_rsp_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_bad_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 4'd4 && req_size != 4'd8) |=> rsp_fault);
  assert_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (in_valid && req_valid && !req_write));
  assert_disk_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disk_valid |-> ($past(req_wdata[31:0]) == 32'h13));
  assert_cpu_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_start_valid |-> (cpu_start_id != '0));
  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({disk_valid, char_valid, cpu_start_valid}));
  assert_strobe_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (disk_valid || char_valid || cpu_start_valid) |-> (rsp_valid && !rsp_fault));
endmodule

// File: tb/tb_sys_console_regs.sv
`timescale 1ns/1ps
module tb_sys_console_regs;
  localparam logic [31:0] E_LAYOUT = 32'h0000_007C;
  localparam logic [31:0] E_REV    = 32'h0000_0A01;
  localparam logic [31:0] E_NCPU   = 32'd4;
  localparam logic [63:0] E_MHZ    = 64'd500;
  localparam logic [63:0] E_MEM    = 64'h0000_0000_4000_0000;
  localparam logic [63:0] E_ENTRY  = 64'hFFFF_FC00_0031_0100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [3:0]  req_size;
  logic [63:0] req_wdata;
  logic        rsp_valid, rsp_fault, in_valid, in_ready;
  logic [63:0] rsp_rdata;
  logic [7:0]  in_data, char_data;
  logic        char_valid, disk_valid, cpu_start_valid;
  logic [63:0] disk_paddr, disk_block, disk_count, cpu_start_param;
  logic [31:0] cpu_start_id;

  int checks = 0;
  int fails  = 0;

  logic [63:0] r_data;
  logic        r_fault, r_valid, r_pop, r_char, r_disk, r_cpu;

  always #2.5 clk = ~clk;

  sys_console_regs dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .char_valid(char_valid), .char_data(char_data), .disk_valid(disk_valid),
    .disk_paddr(disk_paddr), .disk_block(disk_block), .disk_count(disk_count),
    .cpu_start_valid(cpu_start_valid), .cpu_start_id(cpu_start_id),
    .cpu_start_param(cpu_start_param)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] addr, input logic [3:0] sz,
                        input logic [63:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
    #1 r_pop = in_ready;
    @(posedge clk);
    @(negedge clk);
    r_valid = rsp_valid; r_data = rsp_rdata; r_fault = rsp_fault;
    r_char = char_valid; r_disk = disk_valid; r_cpu = cpu_start_valid;
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 rsp_valid", {63'b0, rsp_valid}, 64'd0);
    check("R10 strobes", {61'b0, char_valid, disk_valid, cpu_start_valid}, 64'd0);
    access(1'b0, 32'h38, 4'd8, 64'd0);
    check("R10 unit reg", r_data, 64'd0);
    access(1'b0, 32'h70, 4'd8, 64'd0);
    check("R10 context reg", r_data, 64'd0);
  endtask

  task automatic t_response();
    access(1'b0, 32'h08, 4'd4, 64'd0);
    check("R1 rsp_valid", {63'b0, r_valid}, 64'd1);
    @(negedge clk);
    check("R1 idle no rsp", {63'b0, rsp_valid}, 64'd0);
  endtask

  task automatic t_params();
    access(1'b0, 32'h04, 4'd4, 64'd0);
    check("R3 revision", r_data, {32'b0, E_REV});
    access(1'b0, 32'h08, 4'd4, 64'd0);
    check("R3 cpu count", r_data, {32'b0, E_NCPU});
    access(1'b0, 32'h00, 4'd8, 64'd0);
    check("R3 pair read", r_data, {E_REV, E_LAYOUT});
    access(1'b0, 32'h10, 4'd8, 64'd0);
    check("R3 cpu mhz", r_data, E_MHZ);
    access(1'b0, 32'h1C, 4'd4, 64'd0);
    check("R3 mem upper word", r_data, {32'b0, E_MEM[63:32]});
    access(1'b0, 32'h30, 4'd8, 64'd0);
    check("R3 entry", r_data, E_ENTRY);
  endtask

  task automatic t_store();
    access(1'b1, 32'h38, 4'd8, 64'hDEAD_BEEF_0123_4567);
    check("R5 write no fault", {63'b0, r_fault}, 64'd0);
    access(1'b0, 32'h38, 4'd8, 64'd0);
    check("R5 unit readback", r_data, 64'hDEAD_BEEF_0123_4567);
    access(1'b1, 32'h48, 4'd4, 64'hAAAA_BBBB_1234_5678);
    access(1'b0, 32'h48, 4'd8, 64'd0);
    check("R5 4-byte write zero-extends", r_data, 64'h0000_0000_1234_5678);
  endtask

  task automatic t_illegal();
    access(1'b1, 32'h38, 4'd2, 64'h55);
    check("R2 size 2 fault", {63'b0, r_fault}, 64'd1);
    access(1'b1, 32'h3C, 4'd8, 64'h66);
    check("R2 misaligned fault", {63'b0, r_fault}, 64'd1);
    access(1'b1, 32'h60, 4'd1, 64'h41);
    check("R2 no char strobe", {63'b0, r_char}, 64'd0);
    access(1'b0, 32'h3A, 4'd4, 64'd0);
    check("R2 misaligned read fault", {63'b0, r_fault}, 64'd1);
    access(1'b0, 32'h38, 4'd8, 64'd0);
    check("R2 unit unchanged", r_data, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_input();
    in_valid = 1'b1; in_data = 8'h41;
    access(1'b0, 32'h68, 4'd8, 64'd0);
    check("R4 char read", r_data, 64'h41);
    check("R4 pop", {63'b0, r_pop}, 64'd1);
    access(1'b0, 32'h6C, 4'd4, 64'd0);
    check("R4 upper word zero", r_data, 64'd0);
    check("R4 upper word no pop", {63'b0, r_pop}, 64'd0);
    in_valid = 1'b0;
    access(1'b0, 32'h68, 4'd4, 64'd0);
    check("R4 empty read", r_data, 64'd0);
    check("R4 empty no pop", {63'b0, r_pop}, 64'd0);
  endtask

  task automatic t_disk();
    access(1'b1, 32'h40, 4'd8, 64'd16);
    access(1'b1, 32'h50, 4'd8, 64'd777);
    access(1'b1, 32'h58, 4'd8, 64'h13);
    check("R6 disk strobe", {63'b0, r_disk}, 64'd1);
    check("R6 disk paddr", disk_paddr, 64'h1234_5678);
    check("R6 disk block", disk_block, 64'd777);
    check("R6 disk count", disk_count, 64'd16);
    access(1'b1, 32'h58, 4'd8, 64'h12);
    check("R6 bad op fault", {63'b0, r_fault}, 64'd1);
    check("R6 bad op no strobe", {63'b0, r_disk}, 64'd0);
  endtask

  task automatic t_char();
    access(1'b1, 32'h60, 4'd8, 64'h1234_56C3);
    check("R7 char strobe", {63'b0, r_char}, 64'd1);
    check("R7 char byte", {56'b0, char_data}, 64'hC3);
  endtask

  task automatic t_cpu();
    access(1'b1, 32'h70, 4'd8, 64'h0000_0001_0000_2000);
    access(1'b1, 32'h78, 4'd4, 64'd3);
    check("R8 start strobe", {63'b0, r_cpu}, 64'd1);
    check("R8 start id", {32'b0, cpu_start_id}, 64'd3);
    check("R8 start param", cpu_start_param, 64'h0000_0001_0000_2000);
    access(1'b1, 32'h78, 4'd4, 64'd0);
    check("R8 cpu 0 fault", {63'b0, r_fault}, 64'd1);
    check("R8 cpu 0 no strobe", {63'b0, r_cpu}, 64'd0);
  endtask

  task automatic t_readonly();
    access(1'b1, 32'h04, 4'd4, 64'h9999);
    check("R9 fixed write fault", {63'b0, r_fault}, 64'd1);
    access(1'b0, 32'h04, 4'd4, 64'd0);
    check("R9 revision unchanged", r_data, {32'b0, E_REV});
    access(1'b1, 32'h3C, 4'd4, 64'h7777);
    check("R9 upper half fault", {63'b0, r_fault}, 64'd1);
    access(1'b0, 32'h38, 4'd8, 64'd0);
    check("R9 unit unchanged", r_data, 64'hDEAD_BEEF_0123_4567);
    access(1'b1, 32'h68, 4'd8, 64'h1);
    check("R9 input write fault", {63'b0, r_fault}, 64'd1);
  endtask

  task automatic t_alias();
    access(1'b0, 32'h1000_0004, 4'd4, 64'd0);
    check("R11 alias read", r_data, {32'b0, E_REV});
    access(1'b1, 32'hFFFF_FF40, 4'd8, 64'd99);
    access(1'b0, 32'h40, 4'd8, 64'd0);
    check("R11 alias write", r_data, 64'd99);
    access(1'b1, 32'h8000_0060, 4'd4, 64'h5A);
    check("R12 single strobe", {61'b0, r_char, r_disk, r_cpu}, 64'd4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual hung expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = 4'd4; req_wdata = '0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_response();
    t_params();
    t_store();
    t_illegal();
    t_input();
    t_disk();
    t_char();
    t_cpu();
    t_readonly();
    t_alias();
    repeat (2) @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule